// File: doc/BRIEF.md
# Bus Cycle Sequencer with Wait States

This block runs single bus cycles on behalf of a processor core for a 16-bit data bus with a 24-bit byte address. The core hands over one request at a time through a valid/ready handshake. A request carries the address, the direction, the size (byte or word) and whether it is an instruction fetch or a data access. The sequencer raises the address strobe and then the data strobes. It keeps the cycle open, one clock at a time, until the slave's acknowledge or bus-error input arrives through a two-flop synchronizer. A read cycle returns its data on a one-cycle response pulse.

Faults go to an exception unit on a one-cycle pulse. The pulse carries a 2-bit kind, a vector number, the faulting address and the 5-bit bus status code that was driven for that cycle. A bus error abandons the open cycle. A word access to an odd address is caught when the request is accepted, so no strobe is ever raised for it.

A stop request loads a 16-bit status word and parks the sequencer in an idle state. It leaves that state once the interrupt level input reaches the mask held in that status word.

Top module: `bus_wait_seq`

## Requirements
- R1: While reset is held and right after it: `req_ready`=1, `bus_as`/`bus_uds`/`bus_lds`=0, `rsp_valid`=`exc_valid`=0, `stopped`=0, `status_out`=16'h2700.
- R2: An accepted aligned request raises `bus_as`, with `bus_addr` and `bus_rw` (1=read) valid, in the clock after acceptance. Data strobes follow one clock later. A word drives both strobes. A byte drives `bus_uds` for an even address and `bus_lds` for an odd one. The strobes never appear without `bus_as`.
- R3: While neither acknowledge nor bus error has been seen, the cycle is extended one clock at a time with address and strobes held. With the slave raising its answer in strobe clock W+1, the strobes stay high for exactly W+3 clocks.
- R4: Acknowledge is observed after two synchronizer flops. The clock after that, the strobes and `bus_as` drop and `rsp_valid` pulses for one clock with `rsp_rdata` holding the sampled bus data.
- R5: A bus error during strobes ends the cycle with no response. It gives one `exc_valid` pulse with `exc_kind`=2'b01, `exc_vector`=2, `exc_addr` equal to the cycle address, and `exc_code` equal to that cycle's status code.
- R6: When bus error and acknowledge are seen in the same clock, the bus error wins: no response pulse, only the exception.
- R7: A word request at an odd address raises no `bus_as`. It gives an `exc_valid` pulse in the clock after acceptance with `exc_kind`=2'b10, `exc_vector`=3 and `exc_addr` equal to the request address.
- R8: `bus_fc` during a cycle is {read, not in exception processing, supervisor, fetch ? 2'b10 : 2'b01} (bit 4 down to bit 0).
- R9: An accepted stop request loads `req_stop_sr` into `status_out`, and `stopped` rises in the next clock.
- R10: While stopped, `req_ready` and `bus_as` stay low. The sequencer returns to idle only in the clock after `irq_lvl` is greater than or equal to `status_out[10:8]`.
- R11: A byte access at an odd address is a normal cycle, not an address error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 24 | Byte address of the access |
| req_read | input | 1 | 1 = read, 0 = write |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_prog | input | 1 | 1 = instruction fetch, 0 = data |
| req_wdata | input | 16 | Write data |
| req_stop | input | 1 | Request is a stop, not a bus access |
| req_stop_sr | input | 16 | Status word loaded on stop |
| core_super | input | 1 | Core is in supervisor state |
| core_exc | input | 1 | Core is in exception processing |
| rsp_valid | output | 1 | Read/write completed pulse |
| rsp_rdata | output | 16 | Data sampled at acknowledge |
| exc_valid | output | 1 | Fault pulse |
| exc_kind | output | 2 | 01 bus error, 10 address error |
| exc_vector | output | 8 | Vector number of the fault |
| exc_addr | output | 24 | Faulting address |
| exc_code | output | 5 | Status code of the faulting access |
| bus_addr | output | 24 | Bus address |
| bus_as | output | 1 | Address strobe, active high |
| bus_uds | output | 1 | Upper byte strobe, active high |
| bus_lds | output | 1 | Lower byte strobe, active high |
| bus_rw | output | 1 | 1 = read |
| bus_wdata | output | 16 | Write data on the bus |
| bus_fc | output | 5 | Bus status code |
| bus_rdata | input | 16 | Read data from the slave |
| bus_ack | input | 1 | Asynchronous acknowledge |
| bus_err | input | 1 | Asynchronous bus error |
| irq_lvl | input | 3 | Pending interrupt level |
| stopped | output | 1 | Sequencer is in the stop state |
| status_out | output | 16 | Status word held by the sequencer |

## Verification
Some properties are checked on every clock. The strobes only appear under the address strobe, and the address does not move during a wait clock. Response and fault never pulse together. An address error never follows a raised address strobe, and a bus error only follows a strobed clock. The stopped state keeps the bus and the handshake quiet and is left only at a sufficient interrupt level. Other properties can only be shown by the bench's scenarios and its per-clock reference model: the exact number of wait clocks for a given slave latency, the returned data, the status code for each mix of fetch, direction and mode, the loaded status word, and that an odd byte access runs normally.

// File: rtl/bws_pkg.sv
package bws_pkg;

  localparam int SR_W     = 16;
  localparam int LVL_W    = 3;
  localparam int MASK_LSB = 8;
  localparam int CODE_W   = 5;
  localparam int VEC_W    = 8;

  localparam logic [VEC_W-1:0] VEC_BUS  = 8'd2;
  localparam logic [VEC_W-1:0] VEC_ADDR = 8'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WAIT,
    ST_STOP
  } seq_state_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_BUS  = 2'b01,
    FLT_ADDR = 2'b10
  } fault_kind_t;

  // status code: read, normal execution, supervisor, space select
  function automatic logic [CODE_W-1:0] make_code(input logic rd, input logic in_exc,
                                                  input logic sup, input logic fetch);
    logic [1:0] space;
    space = fetch ? 2'b10 : 2'b01;
    return {rd, ~in_exc, sup, space};
  endfunction

  // {upper, lower} byte lane selection
  function automatic logic [1:0] lane_select(input logic wide, input logic odd);
    if (wide) return 2'b11;
    return odd ? 2'b01 : 2'b10;
  endfunction

  function automatic logic level_reaches(input logic [LVL_W-1:0] lvl,
                                         input logic [LVL_W-1:0] mask);
    return lvl >= mask;
  endfunction

endpackage

// File: rtl/bws_sync.sv
module bws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bws_req_decode.sv
module bws_req_decode
  import bws_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0]     addr,
  input  logic              rd,
  input  logic              wide,
  input  logic              fetch,
  input  logic              sup,
  input  logic              in_exc,
  output logic              misaligned,
  output logic [CODE_W-1:0] code,
  output logic [1:0]        lanes
);
  always_comb begin
    misaligned = wide & addr[0];
    code       = make_code(rd, in_exc, sup, fetch);
    lanes      = lane_select(wide, addr[0]);
  end
endmodule

// File: rtl/bws_stop_ctl.sv
module bws_stop_ctl
  import bws_pkg::*;
#(
  parameter logic [SR_W-1:0] RST_SR = 16'h2700
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SR_W-1:0]  load_val,
  input  logic [LVL_W-1:0] irq_lvl,
  output logic [SR_W-1:0]  sr_q,
  output logic             wake
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sr_q <= RST_SR;
    else if (load) sr_q <= load_val;
  end

  assign wake = level_reaches(irq_lvl, sr_q[MASK_LSB +: LVL_W]);
endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bws_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_read,
  input  logic              req_word,
  input  logic              req_prog,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_stop,
  input  logic [15:0]       req_stop_sr,
  input  logic              core_super,
  input  logic              core_exc,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              exc_valid,
  output logic [1:0]        exc_kind,
  output logic [7:0]        exc_vector,
  output logic [AW-1:0]     exc_addr,
  output logic [4:0]        exc_code,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_as,
  output logic              bus_uds,
  output logic              bus_lds,
  output logic              bus_rw,
  output logic [DW-1:0]     bus_wdata,
  output logic [4:0]        bus_fc,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [2:0]        irq_lvl,
  output logic              stopped,
  output logic [15:0]       status_out
);
  localparam int N_SYNC = 2;

  seq_state_t st, st_nx;

  logic [AW-1:0]     cyc_addr;
  logic              cyc_read;
  logic [DW-1:0]     cyc_wdata;
  logic [CODE_W-1:0] cyc_code;
  logic [1:0]        cyc_lanes;

  logic              dec_mis;
  logic [CODE_W-1:0] dec_code;
  logic [1:0]        dec_lanes;

  logic [N_SYNC-1:0] raw_in, sync_out;
  logic ack_s, berr_s;
  logic wake;

  // named events
  logic accept, stop_enter, addr_fault, issue;
  logic strobing, wait_cycle, ack_seen, berr_seen, stop_exit;

  assign raw_in = {bus_err, bus_ack};

  generate
    for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
      bws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in[i]),
        .q     (sync_out[i])
      );
    end
  endgenerate

  assign ack_s  = sync_out[0];
  assign berr_s = sync_out[1];

  bws_req_decode #(.AW(AW)) u_dec (
    .addr       (req_addr),
    .rd         (req_read),
    .wide       (req_word),
    .fetch      (req_prog),
    .sup        (core_super),
    .in_exc     (core_exc),
    .misaligned (dec_mis),
    .code       (dec_code),
    .lanes      (dec_lanes)
  );

  bws_stop_ctl u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stop_enter),
    .load_val (req_stop_sr),
    .irq_lvl  (irq_lvl),
    .sr_q     (status_out),
    .wake     (wake)
  );

  assign accept     = req_valid && (st == ST_IDLE);
  assign stop_enter = accept && req_stop;
  assign addr_fault = accept && !req_stop && dec_mis;
  assign issue      = accept && !req_stop && !dec_mis;
  assign strobing   = (st == ST_DATA) || (st == ST_WAIT);
  assign wait_cycle = (st == ST_WAIT);
  assign berr_seen  = strobing && berr_s;
  assign ack_seen   = strobing && ack_s && !berr_s;
  assign stop_exit  = (st == ST_STOP) && wake;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: begin
        if (stop_enter)  st_nx = ST_STOP;
        else if (issue)  st_nx = ST_ADDR;
      end
      ST_ADDR: st_nx = ST_DATA;
      ST_DATA, ST_WAIT: begin
        if (berr_seen || ack_seen) st_nx = ST_IDLE;
        else                       st_nx = ST_WAIT;
      end
      ST_STOP: if (stop_exit) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_addr  <= '0;
      cyc_read  <= 1'b1;
      cyc_wdata <= '0;
      cyc_code  <= '0;
      cyc_lanes <= '0;
    end else if (issue) begin
      cyc_addr  <= req_addr;
      cyc_read  <= req_read;
      cyc_wdata <= req_wdata;
      cyc_code  <= dec_code;
      cyc_lanes <= dec_lanes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= ack_seen;
      if (ack_seen) rsp_rdata <= bus_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid  <= 1'b0;
      exc_kind   <= FLT_NONE;
      exc_vector <= '0;
      exc_addr   <= '0;
      exc_code   <= '0;
    end else begin
      exc_valid <= addr_fault || berr_seen;
      if (addr_fault) begin
        exc_kind   <= FLT_ADDR;
        exc_vector <= VEC_ADDR;
        exc_addr   <= req_addr;
        exc_code   <= dec_code;
      end else if (berr_seen) begin
        exc_kind   <= FLT_BUS;
        exc_vector <= VEC_BUS;
        exc_addr   <= cyc_addr;
        exc_code   <= cyc_code;
      end
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign stopped   = (st == ST_STOP);
  assign bus_as    = (st == ST_ADDR) || strobing;
  assign bus_uds   = strobing && cyc_lanes[1];
  assign bus_lds   = strobing && cyc_lanes[0];
  assign bus_addr  = cyc_addr;
  assign bus_rw    = cyc_read;
  assign bus_wdata = cyc_wdata;
  assign bus_fc    = bus_as ? cyc_code : '0;
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_as,
  input logic          bus_uds,
  input logic          bus_lds,
  input logic [AW-1:0] bus_addr,
  input logic          req_ready,
  input logic          stopped,
  input logic          rsp_valid,
  input logic          exc_valid,
  input logic [1:0]    exc_kind,
  input logic          wait_cycle,
  input logic [2:0]    irq_lvl,
  input logic [15:0]   status_out
);
  AST_STROBE_UNDER_AS: assert property (@(posedge clk) disable iff (!rst_n) (bus_uds || bus_lds) |-> bus_as); // R2
  AST_WAIT_HOLDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wait_cycle |-> ($stable(bus_addr) && (bus_uds || bus_lds))); // R3
  AST_RSP_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !bus_as); // R4
  AST_BERR_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (exc_valid && exc_kind == 2'b01) |-> $past(bus_uds || bus_lds)); // R5
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(rsp_valid && exc_valid)); // R6
  AST_ADDRERR_NO_AS: assert property (@(posedge clk) disable iff (!rst_n) (exc_valid && exc_kind == 2'b10) |-> (!bus_as && !$past(bus_as))); // R7
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) stopped |-> (!bus_as && !req_ready)); // R10
  AST_STOP_EXIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) ($past(stopped) && !stopped) |-> ($past(irq_lvl) >= $past(status_out[10:8]))); // R10
endmodule

bind bus_wait_seq bws_checker #(.AW(AW)) u_bws_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_as     (bus_as),
  .bus_uds    (bus_uds),
  .bus_lds    (bus_lds),
  .bus_addr   (bus_addr),
  .req_ready  (req_ready),
  .stopped    (stopped),
  .rsp_valid  (rsp_valid),
  .exc_valid  (exc_valid),
  .exc_kind   (exc_kind),
  .wait_cycle (wait_cycle),
  .irq_lvl    (irq_lvl),
  .status_out (status_out)
);

// File: tb/test_bus_wait_seq.sv
`timescale 1ns/1ps
module test_bus_wait_seq;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_read = 0, req_word = 0, req_prog = 0, req_stop = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0, req_stop_sr = 0;
  logic core_super = 0, core_exc = 0;
  logic req_ready, rsp_valid, exc_valid;
  logic [15:0] rsp_rdata;
  logic [1:0] exc_kind;
  logic [7:0] exc_vector;
  logic [23:0] exc_addr, bus_addr;
  logic [4:0] exc_code, bus_fc;
  logic bus_as, bus_uds, bus_lds, bus_rw;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = 0;
  logic bus_ack = 0, bus_err = 0;
  logic [2:0] irq_lvl = 0;
  logic stopped;
  logic [15:0] status_out;

  bus_wait_seq i_bus_wait_seq (.*);

  int n_chk = 0, n_fail = 0;
  int sl_waits = 0, sl_mode = 0, sl_cnt = 0;
  int strobe_cycles = 0, as_cycles = 0, n_rsp = 0, n_exc = 0;
  logic [1:0] last_kind;
  logic [4:0] last_fc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // slave: answers in strobe clock sl_waits+1; mode 0 ack, 1 error, 2 both
  always @(negedge clk) begin
    if (bus_as && (bus_uds || bus_lds)) begin
      sl_cnt++;
      strobe_cycles++;
      if (sl_cnt > sl_waits) begin
        bus_ack <= (sl_mode != 1);
        bus_err <= (sl_mode != 0);
      end
    end else if (!bus_as) begin
      bus_ack <= 0;
      bus_err <= 0;
      sl_cnt = 0;
    end
    if (bus_as) begin
      as_cycles++;
      last_fc = bus_fc;
    end
    bus_rdata <= bus_addr[15:0] ^ 16'hA55A;
  end

  // behavioural reference model
  int m_ph;            // 0 idle, 1 address, 2 strobing, 3 stopped
  logic [23:0] m_addr, m_eaddr;
  logic m_read, m_word, m_rsp, m_exc;
  logic [4:0] m_code, m_ecode;
  logic [15:0] m_wdata, m_rdata, m_sr;
  logic [1:0] m_kind;
  logic [7:0] m_vec;
  logic [1:0] m_ack_q, m_err_q;

  function automatic logic [4:0] ref_code(input logic rd, input logic ex,
                                          input logic sp, input logic pf);
    logic [4:0] c;
    c = 0;
    c[4] = rd;
    c[3] = !ex;
    c[2] = sp;
    if (pf) c[1] = 1; else c[0] = 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_rsp = 0; m_exc = 0; m_sr = 16'h2700;
      m_ack_q = 0; m_err_q = 0; m_addr = 0; m_read = 1; m_word = 0;
    end else begin
      m_rsp = 0; m_exc = 0;
      case (m_ph)
        0: if (req_valid) begin
          if (req_stop) begin
            m_sr = req_stop_sr; m_ph = 3;
          end else if (req_word && req_addr[0]) begin
            m_exc = 1; m_kind = 2'b10; m_vec = 3; m_eaddr = req_addr;
            m_ecode = ref_code(req_read, core_exc, core_super, req_prog);
          end else begin
            m_addr = req_addr; m_read = req_read; m_word = req_word;
            m_wdata = req_wdata;
            m_code = ref_code(req_read, core_exc, core_super, req_prog);
            m_ph = 1;
          end
        end
        1: m_ph = 2;
        2: if (m_err_q[1]) begin
          m_exc = 1; m_kind = 2'b01; m_vec = 2; m_eaddr = m_addr; m_ecode = m_code;
          m_ph = 0;
        end else if (m_ack_q[1]) begin
          m_rsp = 1; m_rdata = m_addr[15:0] ^ 16'hA55A; m_ph = 0;
        end
        3: if (irq_lvl >= m_sr[10:8]) m_ph = 0;
        default: m_ph = 0;
      endcase
      m_ack_q = {m_ack_q[0], bus_ack};
      m_err_q = {m_err_q[0], bus_err};
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_as, e_uds, e_lds;
      e_as  = (m_ph == 1) || (m_ph == 2);
      e_uds = (m_ph == 2) && (m_word || !m_addr[0]);
      e_lds = (m_ph == 2) && (m_word || m_addr[0]);
      chk(req_ready == (m_ph == 0), "R10", "req_ready", req_ready, m_ph == 0);
      chk(stopped == (m_ph == 3), "R9", "stopped", stopped, m_ph == 3);
      chk(bus_as == e_as, "R2", "bus_as", bus_as, e_as);
      chk(bus_uds == e_uds, "R3", "bus_uds", bus_uds, e_uds);
      chk(bus_lds == e_lds, "R11", "bus_lds", bus_lds, e_lds);
      chk(status_out == m_sr, "R9", "status_out", status_out, m_sr);
      if (e_as) begin
        chk(bus_addr == m_addr, "R2", "bus_addr", bus_addr, m_addr);
        chk(bus_rw == m_read, "R2", "bus_rw", bus_rw, m_read);
        chk(bus_fc == m_code, "R8", "bus_fc", bus_fc, m_code);
        if (!m_read) chk(bus_wdata == m_wdata, "R2", "bus_wdata", bus_wdata, m_wdata);
      end
      chk(rsp_valid == m_rsp, "R4", "rsp_valid", rsp_valid, m_rsp);
      if (m_rsp) chk(rsp_rdata == m_rdata, "R4", "rsp_rdata", rsp_rdata, m_rdata);
      chk(exc_valid == m_exc, "R5", "exc_valid", exc_valid, m_exc);
      if (m_exc) begin
        chk(exc_kind == m_kind, m_kind == 2'b10 ? "R7" : "R5", "exc_kind", exc_kind, m_kind);
        chk(exc_vector == m_vec, m_kind == 2'b10 ? "R7" : "R5", "exc_vector", exc_vector, m_vec);
        chk(exc_addr == m_eaddr, m_kind == 2'b10 ? "R7" : "R5", "exc_addr", exc_addr, m_eaddr);
        chk(exc_code == m_ecode, "R8", "exc_code", exc_code, m_ecode);
      end
      if (rsp_valid) n_rsp++;
      if (exc_valid) begin n_exc++; last_kind = exc_kind; end
    end
  end

  task automatic access(input logic [23:0] a, input logic rd, input logic wd,
                        input logic pf, input int waits, input int mode);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sl_waits = waits; sl_mode = mode;
    strobe_cycles = 0; as_cycles = 0; n_rsp = 0; n_exc = 0;
    req_addr = a; req_read = rd; req_word = wd; req_prog = pf;
    req_wdata = a[15:0] + 16'h1111; req_stop = 0; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic do_stop(input logic [15:0] sr, input logic [2:0] low_lvl,
                         input logic [2:0] wake_lvl);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    irq_lvl = low_lvl; req_stop = 1; req_stop_sr = sr; req_valid = 1;
    @(negedge clk);
    req_valid = 0; req_stop = 0;
    if (low_lvl < sr[10:8]) begin
      repeat (8) @(negedge clk);
      chk(stopped == 1, "R10", "still stopped below mask", stopped, 1);
      chk(req_ready == 0, "R10", "ready low while stopped", req_ready, 0);
    end
    chk(status_out == sr, "R9", "status loaded", status_out, sr);
    irq_lvl = wake_lvl;
    @(negedge clk);
    @(negedge clk);
    chk(stopped == 0, "R10", "left stop at level", stopped, 0);
    irq_lvl = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=%0d expected<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
    chk({bus_as, bus_uds, bus_lds} == 0, "R1", "reset strobes", {bus_as, bus_uds, bus_lds}, 0);
    chk({rsp_valid, exc_valid, stopped} == 0, "R1", "reset pulses", {rsp_valid, exc_valid, stopped}, 0);
    chk(status_out == 16'h2700, "R1", "reset status", status_out, 16'h2700);
    rst_n = 1;

    for (int w = 0; w < 4; w++) begin
      core_super = w[0]; core_exc = w[1];
      access(24'h001000 + 24'(w * 2), 1, 1, w[0], w, 0);
      chk(strobe_cycles == w + 3, "R3", "strobe clocks", strobe_cycles, w + 3);
      chk(n_rsp == 1 && n_exc == 0, "R4", "one response", n_rsp, 1);
      chk(last_fc == ref_code(1, w[1], w[0], w[0]), "R8", "status code", last_fc,
          ref_code(1, w[1], w[0], w[0]));
    end
    core_super = 1; core_exc = 0;
    access(24'h00200A, 0, 0, 0, 2, 0);
    chk(n_rsp == 1, "R2", "even byte write completes", n_rsp, 1);
    access(24'h003003, 1, 0, 0, 1, 0);
    chk(n_exc == 0 && n_rsp == 1, "R11", "odd byte runs normally", n_exc, 0);
    access(24'h004005, 1, 1, 1, 0, 0);
    chk(as_cycles == 0, "R7", "no address strobe", as_cycles, 0);
    chk(n_exc == 1 && last_kind == 2'b10, "R7", "address error", last_kind, 2'b10);
    access(24'h005008, 0, 1, 0, 2, 1);
    chk(n_exc == 1 && n_rsp == 0 && last_kind == 2'b01, "R5", "bus error", last_kind, 2'b01);
    chk(strobe_cycles == 5, "R3", "error strobe clocks", strobe_cycles, 5);
    access(24'h006010, 1, 1, 0, 1, 2);
    chk(n_exc == 1 && n_rsp == 0, "R6", "error beats ack", n_rsp, 0);
    access(24'h007020, 1, 1, 1, 0, 0);
    chk(n_rsp == 1, "R4", "access after error", n_rsp, 1);

    do_stop(16'h2500, 3'd3, 3'd5);
    do_stop(16'h2000, 3'd0, 3'd0);
    do_stop(16'h2700, 3'd6, 3'd7);
    access(24'h008000, 1, 1, 0, 0, 0);
    chk(n_rsp == 1, "R10", "access after stop", n_rsp, 1);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule